// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises firmware by counting ticks of a slow reference clock, presented as single-cycle strobes in the system clock domain. Firmware must service the block with a service strobe before the selected timeout elapses. If it does not, the block raises a one-cycle reset request. Timeouts are set by a 4-bit period code, and eleven codes are valid.

The block has two modes. In standard mode, any service restarts the timeout. In window mode, each restart opens a closed period, whose length is set by a second period code. A service that arrives during the closed period is treated as a fault and causes a reset request. A service that arrives in the open period that follows starts a new closed period.

Configuration arrives as register-style writes. There is one write port for the main field (enable and timeout code) and one for the window field (window enable and closed-period code). Each write carries its own change-enable qualifier. A single permit input stands in for the timed unlock sequence. A sticky lock input freezes the whole configuration until the next reset.

Top module: `wdog_window`

## Requirements
- R1: In standard mode with no service, the reset request rises exactly when the tick that completes the timeout is taken, and the count starts at the enable write or the last restart.
- R2: A valid period code c (0 to 10) selects a period of 8 × 2^c ticks. This applies both to the timeout code and to the closed-period code.
- R3: A write whose code is reserved (11 to 15) leaves the stored code unchanged. The enable bit of that same write still takes effect.
- R4: The count advances only on clock cycles where the tick input is high. Idle clock cycles between ticks have no effect on when the timeout occurs.
- R5: In standard mode a service restarts the timeout. A service that arrives in the same cycle as the final tick prevents the reset request.
- R6: In window mode a service during the closed period raises the reset request in the next cycle. The closed period is the first 8 × 2^w ticks after a restart, where w is the closed-period code.
- R7: In window mode a service in the open period starts a new closed period without raising a request. Without any service, the request comes after closed-period ticks plus timeout ticks.
- R8: A write changes its field (enable bit and code) only when its change-enable bit is 1. A write whose change-enable bit is 0 has no effect, and neither does it restart the count.
- R9: Once the lock input has been high for one cycle, every later write is ignored until reset. A write issued in the same cycle as the lock is also ignored.
- R10: Writes made while the permit input is low are ignored.
- R11: After any reset request, and after any accepted write, the count restarts from zero. In window mode the restart begins with a closed period.
- R12: While the block is disabled, which is the state after reset, the reset request stays low and services are ignored.
- R13: The reset request lasts exactly one cycle. A service presented during the cycle in which the request is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per reference tick |
| kick_i | input | 1 | Service strobe from firmware |
| permit_i | input | 1 | Unlock permit; writes are accepted only while it is high |
| lock_i | input | 1 | Sets the sticky configuration lock |
| ctl_wr_i | input | 1 | Write strobe for the main field |
| ctl_en_i | input | 1 | Enable value to be written |
| ctl_chg_i | input | 1 | Change-enable for the main field |
| ctl_code_i | input | 4 | Timeout period code |
| win_wr_i | input | 1 | Write strobe for the window field |
| win_en_i | input | 1 | Window-mode enable value to be written |
| win_chg_i | input | 1 | Change-enable for the window field |
| win_code_i | input | 4 | Closed-period code |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume several things about the inputs:
- Every strobe, including tick, service, write and lock, is synchronous to the system clock and is sampled at a single edge.
- The tick is already a clean single-cycle pulse, because any clock-domain crossing happens outside the block.

The bench drives every input at the falling edge and releases each strobe after one cycle, so these assumptions hold. The random phase keeps timeout codes small so that many timeouts and window faults occur. It also mixes in reserved codes, writes with the change-enable bit cleared, and writes while the permit is low. The lock is applied only in the final directed step, because after that no later write can change the configuration.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CODE_W = 4;

  typedef enum logic {PH_CLOSED = 1'b0, PH_OPEN = 1'b1} wd_phase_e;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } wd_field_t;
endpackage

// File: rtl/wdog_field.sv
module wdog_field
  import wdog_pkg::*;
#(
  parameter int NUM_CODES = 11,
  parameter int RST_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic              chg_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output wd_field_t         fld_o,
  output logic              upd_o
);
  wd_field_t fld_q, fld_d;
  logic      code_ok;

  always_comb begin
    code_ok = (int'(code_i) < NUM_CODES);
    upd_o   = acc_i && wr_i && chg_i;
    fld_d   = fld_q;
    fld_d.en = en_i;
    if (code_ok) fld_d.code = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q.en   <= 1'b0;
      fld_q.code <= CODE_W'(RST_CODE);
    end else if (upd_o) begin
      fld_q <= fld_d;
    end
  end

  assign fld_o = fld_q;

  assert_chg_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && chg_i) |=> $stable(fld_o));
  assert_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && int'(code_i) >= NUM_CODES) |=> $stable(fld_o.code));
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int NUM_CODES = 11,
  parameter int RST_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              permit_i,
  input  logic              lock_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_en_i,
  input  logic              ctl_chg_i,
  input  logic [CODE_W-1:0] ctl_code_i,
  input  logic              win_wr_i,
  input  logic              win_en_i,
  input  logic              win_chg_i,
  input  logic [CODE_W-1:0] win_code_i,
  output wd_field_t         main_o,
  output wd_field_t         win_o,
  output logic              restart_o
);
  localparam int NF = 2;

  logic              locked_q;
  logic              acc;
  logic [NF-1:0]     wr, chg, en, upd;
  logic [CODE_W-1:0] code [NF];
  wd_field_t         fld  [NF];

  assign acc = permit_i && !locked_q && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      locked_q <= 1'b0;
    else if (lock_i) locked_q <= 1'b1;
  end

  assign wr   = {win_wr_i,  ctl_wr_i};
  assign chg  = {win_chg_i, ctl_chg_i};
  assign en   = {win_en_i,  ctl_en_i};
  assign code[0] = ctl_code_i;
  assign code[1] = win_code_i;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    wdog_field #(.NUM_CODES(NUM_CODES), .RST_CODE(RST_CODE)) u_fld (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .wr_i(wr[i]), .chg_i(chg[i]),
      .en_i(en[i]), .code_i(code[i]), .fld_o(fld[i]), .upd_o(upd[i])
    );
  end

  assign main_o    = fld[0];
  assign win_o     = fld[1];
  assign restart_o = |upd;

  assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> ($stable(main_o) && $stable(win_o)));
  assert_permit_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !permit_i |=> ($stable(main_o) && $stable(win_o)));
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int CNT_W     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              restart_i,
  input  logic              en_i,
  input  logic              win_en_i,
  input  logic [CODE_W-1:0] tcode_i,
  input  logic [CODE_W-1:0] wcode_i,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, tlim, wlim, lim;
  wd_phase_e        phase_q, phase_d;
  logic             req_q, req_d, closed_now, cnt_ce;

  always_comb begin
    tlim = CNT_W'((32'd1 << (BASE_LOG2 + int'(tcode_i))) - 32'd1);
    wlim = CNT_W'((32'd1 << (BASE_LOG2 + int'(wcode_i))) - 32'd1);
    closed_now = win_en_i && (phase_q == PH_CLOSED);
    lim     = closed_now ? wlim : tlim;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    req_d   = 1'b0;
    if (!en_i || restart_i) begin
      cnt_d   = '0;
      phase_d = PH_CLOSED;
    end else if (kick_i && !req_q) begin
      req_d   = closed_now;
      cnt_d   = '0;
      phase_d = PH_CLOSED;
    end else if (tick_i) begin
      if (cnt_q == lim) begin
        cnt_d = '0;
        if (closed_now) begin
          phase_d = PH_OPEN;
        end else begin
          req_d   = 1'b1;
          phase_d = PH_CLOSED;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    cnt_ce = !en_i || restart_i || kick_i || tick_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_CLOSED;
    end else if (cnt_ce) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign rst_req_o = req_q;

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);
  assert_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !rst_req_o);
  assert_early_kick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && win_en_i && phase_q == PH_CLOSED && kick_i && !rst_req_o && !restart_i)
      |=> rst_req_o);
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int NUM_CODES = 11,
  parameter int BASE_LOG2 = 3,
  parameter int RST_CODE  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       permit_i,
  input  logic       lock_i,
  input  logic       ctl_wr_i,
  input  logic       ctl_en_i,
  input  logic       ctl_chg_i,
  input  logic [3:0] ctl_code_i,
  input  logic       win_wr_i,
  input  logic       win_en_i,
  input  logic       win_chg_i,
  input  logic [3:0] win_code_i,
  output logic       rst_req_o
);
  localparam int CNT_W = BASE_LOG2 + NUM_CODES - 1;

  wd_field_t main_f, win_f;
  logic      restart;

  wdog_cfg #(.NUM_CODES(NUM_CODES), .RST_CODE(RST_CODE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .permit_i(permit_i), .lock_i(lock_i),
    .ctl_wr_i(ctl_wr_i), .ctl_en_i(ctl_en_i), .ctl_chg_i(ctl_chg_i),
    .ctl_code_i(ctl_code_i), .win_wr_i(win_wr_i), .win_en_i(win_en_i),
    .win_chg_i(win_chg_i), .win_code_i(win_code_i),
    .main_o(main_f), .win_o(win_f), .restart_o(restart)
  );

  wdog_cnt #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
    .restart_i(restart), .en_i(main_f.en), .win_en_i(win_f.en),
    .tcode_i(main_f.code), .wcode_i(win_f.code), .rst_req_o(rst_req_o)
  );
endmodule

// File: tb/wdog_window_tb.sv
module wdog_window_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, kick = 0, permit = 1, lock = 0;
  logic ctl_wr = 0, ctl_en = 0, ctl_chg = 0, win_wr = 0, win_en = 0, win_chg = 0;
  logic [3:0] ctl_code = 0, win_code = 0;
  logic rst_req;

  int total = 0, bad = 0;
  string tag = "R12";

  // model state
  bit m_en = 0, m_wen = 0, m_lock = 0, m_req = 0, m_closed = 1;
  int m_per = 0, m_wper = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  wdog_window u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .kick_i(kick), .permit_i(permit),
    .lock_i(lock), .ctl_wr_i(ctl_wr), .ctl_en_i(ctl_en), .ctl_chg_i(ctl_chg),
    .ctl_code_i(ctl_code), .win_wr_i(win_wr), .win_en_i(win_en),
    .win_chg_i(win_chg), .win_code_i(win_code), .rst_req_o(rst_req)
  );

  function automatic int ticks_of(int c);
    return 8 << c;
  endfunction

  task automatic chk(bit ok, string t, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit acc, restart, req, closed;
    int lim;
    acc = permit && !(m_lock || lock);
    restart = (acc && ctl_wr && ctl_chg) || (acc && win_wr && win_chg);
    closed = m_wen && m_closed;
    lim = closed ? ticks_of(m_wper) : ticks_of(m_per);
    req = 0;
    if (!m_en || restart) begin
      m_cnt = 0; m_closed = 1;
    end else if (kick && !m_req) begin
      req = closed; m_cnt = 0; m_closed = 1;
    end else if (tick) begin
      if (m_cnt == lim - 1) begin
        m_cnt = 0;
        if (closed) m_closed = 0;
        else begin req = 1; m_closed = 1; end
      end else m_cnt++;
    end
    if (acc && ctl_wr && ctl_chg) begin
      m_en = ctl_en;
      if (ctl_code <= 10) m_per = ctl_code;
    end
    if (acc && win_wr && win_chg) begin
      m_wen = win_en;
      if (win_code <= 10) m_wper = win_code;
    end
    m_lock = m_lock || lock;
    m_req = req;
  endtask

  // one clock cycle: inputs already set; compare against model; release strobes
  task automatic cyc();
    model_step();
    @(negedge clk);
    chk(rst_req === m_req, tag, rst_req, m_req);
    tick = 0; kick = 0; lock = 0; ctl_wr = 0; win_wr = 0;
  endtask

  task automatic wr_ctl(bit e, bit c, int code);
    ctl_wr = 1; ctl_en = e; ctl_chg = c; ctl_code = 4'(code); cyc();
  endtask

  task automatic wr_win(bit e, bit c, int code);
    win_wr = 1; win_en = e; win_chg = c; win_code = 4'(code); cyc();
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc();
      for (int g = 0; g < gap; g++) cyc();
    end
  endtask

  // n ticks; request expected only right after the last one
  task automatic expect_timeout(int n, int gap, string t);
    tag = t;
    for (int i = 1; i <= n; i++) begin
      tick = 1; cyc();
      chk(rst_req === (i == n), t, rst_req, i == n);
      for (int g = 0; g < gap; g++) cyc();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    tag = "R12";
    chk(rst_req === 1'b0, "R12 reset", rst_req, 0);
    rst_n = 1;
    @(negedge clk);
    // R12: disabled after reset, kicks and ticks do nothing
    kick = 1; cyc();
    ticks(20, 0);
    chk(rst_req === 1'b0, "R12 idle", rst_req, 0);

    // R1 / R11: standard, code 0 -> 8 ticks, restart after request
    tag = "R1"; wr_ctl(1, 1, 0);
    expect_timeout(8, 0, "R1");
    expect_timeout(8, 0, "R11");
    // R4: idle cycles between ticks do not count
    expect_timeout(8, 3, "R4");
    // R2: codes 2 and 10
    tag = "R2"; wr_ctl(1, 1, 2);
    expect_timeout(32, 0, "R2");
    wr_ctl(1, 1, 10);
    expect_timeout(8192, 0, "R2");
    // R3: reserved code keeps old code
    tag = "R3"; wr_ctl(1, 1, 1); wr_ctl(1, 1, 13);
    expect_timeout(16, 0, "R3");
    // R8: chg=0 ignored
    tag = "R8"; ticks(5, 0); wr_ctl(0, 0, 0); wr_win(1, 0, 0);
    expect_timeout(11, 0, "R8");
    // R12: disable, kicks ignored
    tag = "R12"; wr_ctl(0, 1, 0);
    for (int i = 0; i < 40; i++) begin
      tick = 1; kick = (i % 7 == 0); cyc();
      chk(rst_req === 1'b0, "R12", rst_req, 0);
    end
    // R10: permit low blocks write
    tag = "R10"; permit = 0; wr_ctl(1, 1, 0); permit = 1;
    ticks(20, 0);
    chk(rst_req === 1'b0, "R10", rst_req, 0);

    // R5: kick restarts; kick with final tick prevents reset
    tag = "R5"; wr_ctl(1, 1, 0);
    ticks(7, 0); kick = 1; cyc();
    ticks(7, 0); tick = 1; kick = 1; cyc();
    chk(rst_req === 1'b0, "R5", rst_req, 0);
    expect_timeout(8, 0, "R5");

    // window: timeout 16, closed 8
    tag = "R6"; wr_ctl(1, 1, 1); wr_win(1, 1, 0);
    ticks(3, 0); kick = 1; cyc();
    chk(rst_req === 1'b1, "R6", rst_req, 1);
    // R13: kick during pulse ignored
    tag = "R13"; kick = 1; cyc();
    chk(rst_req === 1'b0, "R13", rst_req, 0);
    // R7: open-window kick restarts closed window
    tag = "R7"; ticks(8, 0); ticks(5, 0); kick = 1; cyc();
    chk(rst_req === 1'b0, "R7", rst_req, 0);
    ticks(7, 0); kick = 1; cyc();
    chk(rst_req === 1'b1, "R7 closed again", rst_req, 1);
    expect_timeout(24, 0, "R7");

    // random phase
    tag = "R11";
    for (int i = 0; i < 5000; i++) begin
      tick = ($urandom_range(0, 1) == 1);
      kick = ($urandom_range(0, 29) == 0);
      permit = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 149) == 0) begin
        ctl_wr = 1; ctl_en = ($urandom_range(0, 5) != 0); ctl_chg = ($urandom_range(0, 3) != 0);
        ctl_code = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(11, 15)) : 4'($urandom_range(0, 2));
      end
      if ($urandom_range(0, 149) == 0) begin
        win_wr = 1; win_en = $urandom_range(0, 1) == 1; win_chg = ($urandom_range(0, 3) != 0);
        win_code = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(11, 15)) : 4'($urandom_range(0, 2));
      end
      cyc();
    end
    permit = 1;

    // R9: lock freezes configuration
    tag = "R9"; wr_ctl(1, 1, 0); wr_win(0, 1, 0);
    lock = 1; ctl_wr = 1; ctl_en = 0; ctl_chg = 1; ctl_code = 4'd3; cyc();
    wr_ctl(0, 1, 2); wr_win(1, 1, 0);
    expect_timeout(8, 0, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule